// File: doc/BRIEF.md
# SMBus Block-Transfer Register Slave

This block is a small SMBus slave for standard-mode traffic. It gives a host access to seven 8-bit control bytes that configure a clock generator. The slave samples SCL and SDA with the system clock through a short synchronizer. It detects START and STOP conditions, matches the 7-bit device address 69h, and drives SDA through an open-drain style pull-down output. It does not stretch the clock, arbitrate, time out or check packet error codes.

A write is a block write. After the address byte the host sends two header bytes: a command code, then a byte count. The slave acknowledges both and discards their values. Every data byte after that lands in the next register, starting at byte 0, and the host may stop after any whole byte. Only bytes 0 to 5 can be written. A read is a block read. The slave first sends a byte count of seven, then bytes 0 to 6, most significant bit first. It stops sending as soon as the host declines a byte.

Each control byte mixes bits the host can write, status bits copied from input pins, and reserved bits that read as zero. The merged view of all seven bytes is always driven on `ctrlBytes`, where byte n occupies bits 8n+7 down to 8n, for the clock logic to use.

Top module: `smbus_reg_slave`

## Requirements
- R1: The address byte 0xD2 (address 69h, direction bit 0) selects a write and 0xD3 (direction bit 1) selects a read. The slave acknowledges both by holding SDA low during the ninth clock. SDA only changes while SCL is low.
- R2: An address byte whose upper seven bits are not 69h is not acknowledged. Bytes that follow it up to the next STOP are not acknowledged either, and they change no register.
- R3: In a write, the first two bytes after the address (command code and byte count) are each acknowledged, and their values change no register.
- R4: Write data bytes are acknowledged and load bytes 0, 1, 2 and so on in that order. A STOP after any whole byte ends the transfer and leaves the bytes that were not reached unchanged.
- R5: Data bytes beyond the sixth in one write are still acknowledged but have no effect, and byte 6 can never be written.
- R6: After a read address is acknowledged, the slave sends 0x07 and then bytes 0 to 6, each most significant bit first. It changes SDA after the falling edge of SCL and sends the next byte only if the host acknowledged the previous one.
- R7: When the host does not acknowledge a read byte, the slave releases SDA and keeps it released for any further clocks until the next START or STOP.
- R8: Read-only bits ignore writes. Byte 0 bits 4:3 show the `selStatus` input, byte 1 bit 7 shows `swingStatus`, and byte 6 shows `deviceId`. All other bits that are not writable read as 0.
- R9: Writable bits are byte 0 bits 2:0, byte 1 bits 3:0, byte 2 bits 6:0, byte 3 bits 7:0, byte 4 bits 5:0 and byte 5 bits 3:0. After reset their values are byte 0 = 0x04, byte 1 = 0x0F, byte 2 = 0x7F, byte 3 = 0xC7, byte 4 = 0x3F and byte 5 = 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are sampled on it |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Level of the SMBus clock line |
| sdaIn | input | 1 | Level of the SMBus data line |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 releases it |
| selStatus | input | 2 | Latched select-pin levels, shown in byte 0 bits 4:3 |
| swingStatus | input | 1 | Output swing select level, shown in byte 1 bit 7 |
| deviceId | input | 8 | Identification value returned as byte 6 |
| ctrlBytes | output | 56 | Merged register view, byte n in bits 8n+7:8n |

## Verification
A wrong bit count or a wrong transfer state shows at the ports within one byte time. Either an acknowledge appears on the wrong SCL pulse, or a write lands in the neighbouring register and shows on `ctrlBytes` as soon as the next STOP has passed. A write pointer that is off by one, or one that skips the two header bytes wrongly, corrupts every later data byte of the transfer. That shows in the compared register view and in the block read that follows. A failure to release SDA after a host NACK shows as a low data line on the very next clock pulse the host sends.

// File: rtl/smbus_reg_pkg.sv
package smbus_reg_pkg;

  // Strobes from the link control to the register datapath.
  typedef struct packed {
    logic shiftIn;     // capture one received bit
    logic rxBit;       // the bit value being captured
    logic clearPtr;    // restart the register pointer (write transfer)
    logic commitData;  // store the received byte at the pointer, advance
    logic loadCount;   // load the block-read byte count, restart pointer
    logic loadReg;     // load the byte at the pointer for sending, advance
    logic shiftOut;    // present the next transmit bit
  } xferStrobes_t;

  // Bits the host may write, per register index.
  function automatic logic [7:0] wrMask(input int idx);
    case (idx)
      0: wrMask = 8'h07;
      1: wrMask = 8'h0F;
      2: wrMask = 8'h7F;
      3: wrMask = 8'hFF;
      4: wrMask = 8'h3F;
      5: wrMask = 8'h0F;
      default: wrMask = 8'h00;
    endcase
  endfunction

  // Reset value of the writable bits.
  function automatic logic [7:0] resetVal(input int idx);
    case (idx)
      0: resetVal = 8'h04;
      1: resetVal = 8'h0F;
      2: resetVal = 8'h7F;
      3: resetVal = 8'hC7;
      4: resetVal = 8'h3F;
      default: resetVal = 8'h00;
    endcase
  endfunction

  // Bits fed from status inputs, per register index (last index is the ID byte).
  function automatic logic [7:0] roMask(input int idx, input int lastIdx);
    if (idx == lastIdx) roMask = 8'hFF;
    else if (idx == 0) roMask = 8'h18;
    else if (idx == 1) roMask = 8'h80;
    else roMask = 8'h00;
  endfunction

endpackage

// File: rtl/smbus_link_ctrl.sv
module smbus_link_ctrl
  import smbus_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic [7:0]   rxByte,
  output xferStrobes_t strb,
  output logic         ackLow,
  output logic         driveData,
  output logic         busIdle
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_HOLD
  } linkState_t;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startCond, stopCond;

  linkState_t state, stateNxt;
  logic [3:0] bitCnt, bitCntNxt;
  logic [1:0] wrPhase, wrPhaseNxt;
  logic readMode, readModeNxt;
  logic masterAck, masterAckNxt;
  logic ackLowNxt, driveDataNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond = sclS & sclD & ~sdaD & sdaS;

  always_comb begin
    stateNxt = state;
    bitCntNxt = bitCnt;
    wrPhaseNxt = wrPhase;
    readModeNxt = readMode;
    masterAckNxt = masterAck;
    ackLowNxt = ackLow;
    driveDataNxt = driveData;
    strb = '0;
    strb.rxBit = sdaS;
    if (stopCond) begin
      stateNxt = ST_IDLE;
      ackLowNxt = 1'b0;
      driveDataNxt = 1'b0;
    end else if (startCond) begin
      stateNxt = ST_ADDR;
      bitCntNxt = '0;
      ackLowNxt = 1'b0;
      driveDataNxt = 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise && bitCnt < 4'd8) begin
            strb.shiftIn = 1'b1;
            bitCntNxt = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (rxByte[7:1] == DEV_ADDR) begin
              ackLowNxt = 1'b1;
              readModeNxt = rxByte[0];
              stateNxt = ST_ADDR_ACK;
            end else begin
              stateNxt = ST_HOLD;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackLowNxt = 1'b0;
            if (readMode) begin
              strb.loadCount = 1'b1;
              driveDataNxt = 1'b1;
              bitCntNxt = 4'd1;
              stateNxt = ST_TX;
            end else begin
              strb.clearPtr = 1'b1;
              wrPhaseNxt = '0;
              bitCntNxt = '0;
              stateNxt = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            strb.shiftIn = 1'b1;
            bitCntNxt = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            ackLowNxt = 1'b1;
            stateNxt = ST_RX_ACK;
            if (wrPhase == 2'd2) strb.commitData = 1'b1;
            else wrPhaseNxt = wrPhase + 2'd1;
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            ackLowNxt = 1'b0;
            bitCntNxt = '0;
            stateNxt = ST_RX;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd8) begin
              driveDataNxt = 1'b0;
              stateNxt = ST_TX_ACK;
            end else begin
              strb.shiftOut = 1'b1;
              bitCntNxt = bitCnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            masterAckNxt = ~sdaS;
          end else if (sclFall) begin
            if (masterAck) begin
              strb.loadReg = 1'b1;
              driveDataNxt = 1'b1;
              bitCntNxt = 4'd1;
              stateNxt = ST_TX;
            end else begin
              stateNxt = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      wrPhase <= '0;
      readMode <= 1'b0;
      masterAck <= 1'b0;
      ackLow <= 1'b0;
      driveData <= 1'b0;
    end else begin
      state <= stateNxt;
      bitCnt <= bitCntNxt;
      wrPhase <= wrPhaseNxt;
      readMode <= readModeNxt;
      masterAck <= masterAckNxt;
      ackLow <= ackLowNxt;
      driveData <= driveDataNxt;
    end
  end

  assign busIdle = (state == ST_IDLE) || (state == ST_HOLD);

endmodule

// File: rtl/smbus_reg_datapath.sv
module smbus_reg_datapath
  import smbus_reg_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int NUM_WR = 6,
  parameter logic [7:0] COUNT_VALUE = 8'd7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  xferStrobes_t          strb,
  input  logic [1:0]            selStatus,
  input  logic                  swingStatus,
  input  logic [7:0]            deviceId,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic [8*NUM_REGS-1:0] regView
);

  localparam int PTR_W = $clog2(NUM_REGS + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  logic [PTR_W-1:0] ptr;
  logic [7:0] rxShift, txShift, readSel;
  logic [7:0] stored [NUM_WR];
  logic [7:0] roVec [NUM_REGS];
  logic [7:0] viewArr [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strb.shiftIn) begin
      rxShift <= {rxShift[6:0], strb.rxBit};
    end
  end
  assign rxByte = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.clearPtr || strb.loadCount) begin
      ptr <= '0;
    end else if ((strb.commitData || strb.loadReg) && ptr != PTR_END) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) roVec[i] = '0;
    roVec[0][4:3] = selStatus;
    roVec[1][7] = swingStatus;
    roVec[NUM_REGS-1] = deviceId;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g < NUM_WR) begin : g_rw
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stored[g] <= resetVal(g) & wrMask(g);
        end else if (strb.commitData && ptr == PTR_W'(g)) begin
          stored[g] <= rxShift & wrMask(g);
        end
      end
      assign viewArr[g] = stored[g] | roVec[g];
    end else begin : g_ro
      assign viewArr[g] = roVec[g];
    end
    assign regView[8*g +: 8] = viewArr[g];
  end

  assign readSel = (ptr < PTR_END) ? viewArr[ptr] : 8'hFF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= 8'hFF;
    end else if (strb.loadCount) begin
      txShift <= COUNT_VALUE;
    end else if (strb.loadReg) begin
      txShift <= readSel;
    end else if (strb.shiftOut) begin
      txShift <= {txShift[6:0], 1'b1};
    end
  end
  assign txMsb = txShift[7];

endmodule

// File: rtl/smbus_reg_slave.sv
module smbus_reg_slave
  import smbus_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 7,
  parameter int NUM_WR = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  input  logic [1:0]            selStatus,
  input  logic                  swingStatus,
  input  logic [7:0]            deviceId,
  output logic [8*NUM_REGS-1:0] ctrlBytes
);

  localparam logic [7:0] COUNT_VALUE = 8'(NUM_REGS);

  xferStrobes_t strb;
  logic [7:0] rxByte;
  logic txMsb, ackLow, driveData, busIdle;

  smbus_link_ctrl #(
    .DEV_ADDR(DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .rxByte(rxByte),
    .strb(strb), .ackLow(ackLow), .driveData(driveData), .busIdle(busIdle)
  );

  smbus_reg_datapath #(
    .NUM_REGS(NUM_REGS),
    .NUM_WR(NUM_WR),
    .COUNT_VALUE(COUNT_VALUE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .selStatus(selStatus),
    .swingStatus(swingStatus), .deviceId(deviceId), .rxByte(rxByte),
    .txMsb(txMsb), .regView(ctrlBytes)
  );

  assign sdaDriveLow = ackLow | (driveData & ~txMsb);

endmodule

// File: rtl/smbus_reg_slave_chk.sv
module smbus_reg_slave_chk
  import smbus_reg_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int NUM_WR = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaDriveLow,
  input logic                  busIdle,
  input logic                  commitData,
  input logic [8*NUM_REGS-1:0] ctrlBytes
);

  logic [8*NUM_REGS-1:0] wrAll, rsvdAll;
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_mask
    assign wrAll[8*g +: 8] = (g < NUM_WR) ? wrMask(g) : 8'h00;
    assign rsvdAll[8*g +: 8] = ~(wrAll[8*g +: 8] | roMask(g, NUM_REGS - 1));
  end

  // R7: no pull-down while no transfer is in progress for this slave
  assert_idle_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> !sdaDriveLow);

  // R5: writable bits only move in the cycle after a data commit
  assert_wr_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !commitData |=> $stable(ctrlBytes & wrAll));

  // R8: reserved bits always read as zero
  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBytes & rsvdAll) == '0);

  // R1: pull-down starts only while SCL is low
  assert_pull_scl_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclIn);

  // R6: pull-down ends only while SCL is low
  assert_release_scl_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDriveLow) |-> !sclIn);

endmodule

bind smbus_reg_slave smbus_reg_slave_chk #(
  .NUM_REGS(NUM_REGS),
  .NUM_WR(NUM_WR)
) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .busIdle(busIdle), .commitData(strb.commitData), .ctrlBytes(ctrlBytes)
);

// File: tb/smbus_reg_slave_tb.sv
module smbus_reg_slave_tb_top;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaDriveLow;
  logic [1:0] selStatus = 2'b10;
  logic swingStatus = 1'b1;
  logic [7:0] deviceId = 8'hA5;
  logic [55:0] ctrlBytes;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [7:0] expStore [6];
  logic [7:0] wrBuf [16];
  logic [7:0] rdBuf [16];
  bit ackBuf [16];

  always #2 clk = ~clk;

  assign sdaLine = sdaM & ~sdaDriveLow;

  smbus_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .selStatus(selStatus), .swingStatus(swingStatus),
    .deviceId(deviceId), .ctrlBytes(ctrlBytes)
  );

  // Expected layout, taken from R8 and R9
  function automatic logic [7:0] bMask(int i);
    case (i)
      0: return 8'h07; 1: return 8'h0F; 2: return 8'h7F;
      3: return 8'hFF; 4: return 8'h3F; 5: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bDef(int i);
    case (i)
      0: return 8'h04; 1: return 8'h0F; 2: return 8'h7F;
      3: return 8'hC7; 4: return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expView(int i);
    logic [7:0] v;
    v = (i < 6) ? expStore[i] : 8'h00;
    if (i == 0) v[4:3] = selStatus;
    if (i == 1) v[7] = swingStatus;
    if (i == 6) v = deviceId;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic checkView(input string req);
    for (int i = 0; i < 7; i++)
      check(ctrlBytes[8*i +: 8] == expView(i), req, ctrlBytes[8*i +: 8], expView(i));
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBit(input bit b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic recvBit(output bit b);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); b = sdaLine; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic readByte(input bit ackIt, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(~ackIt);
  endtask

  // Address, command, count, then n data bytes from wrBuf; acks land in ackBuf
  task automatic doWrite(input logic [7:0] addr, input int n, input logic [7:0] cmd, input logic [7:0] cnt);
    bit a;
    busStart();
    writeByte(addr, a); ackBuf[0] = a;
    writeByte(cmd, a);  ackBuf[1] = a;
    writeByte(cnt, a);  ackBuf[2] = a;
    for (int i = 0; i < n; i++) begin
      writeByte(wrBuf[i], a);
      ackBuf[3 + i] = a;
    end
    busStop();
  endtask

  task automatic modelWrite(input int n);
    for (int i = 0; i < n && i < 6; i++) expStore[i] = wrBuf[i] & bMask(i);
  endtask

  task automatic fullReadCheck(input string req);
    bit a;
    busStart();
    writeByte(8'hD3, a);
    check(a, "R1 read address ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < 8; i++) readByte(i != 7, rdBuf[i]);
    busStop();
    check(rdBuf[0] == 8'h07, "R6 byte count", rdBuf[0], 8'h07);
    for (int i = 0; i < 7; i++)
      check(rdBuf[i + 1] == expView(i), req, rdBuf[i + 1], expView(i));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) expStore[i] = bDef(i);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset values with R8 status merge
    checkView("R9 reset view");
    check(sdaDriveLow == 1'b0, "R9 sda released", {7'd0, sdaDriveLow}, 8'h00);
    fullReadCheck("R6 R9 readback after reset");

    // R3 R4: header bytes ignored, two data bytes, rest untouched
    wrBuf[0] = 8'hF8; wrBuf[1] = 8'h05;
    doWrite(8'hD2, 2, 8'hFF, 8'hFF);
    check(ackBuf[0], "R1 write address ack", {7'd0, ackBuf[0]}, 8'h01);
    check(ackBuf[1] && ackBuf[2], "R3 header acks", {6'd0, ackBuf[1], ackBuf[2]}, 8'h03);
    check(ackBuf[3] && ackBuf[4], "R4 data acks", {6'd0, ackBuf[3], ackBuf[4]}, 8'h03);
    modelWrite(2);
    checkView("R4 partial write");

    // R5 R8: eight data bytes, all ones
    for (int i = 0; i < 8; i++) wrBuf[i] = 8'hFF;
    doWrite(8'hD2, 8, 8'h00, 8'h08);
    check(ackBuf[9] && ackBuf[10], "R5 extra bytes acked", {6'd0, ackBuf[9], ackBuf[10]}, 8'h03);
    modelWrite(8);
    checkView("R5 R8 overlong write");

    // R2 wrong address
    for (int i = 0; i < 4; i++) wrBuf[i] = 8'h00;
    doWrite(8'hA4, 4, 8'h00, 8'h04);
    check(!ackBuf[0], "R2 address nack", {7'd0, ackBuf[0]}, 8'h00);
    check(!ackBuf[3] && !ackBuf[5], "R2 data nack", {6'd0, ackBuf[3], ackBuf[5]}, 8'h00);
    checkView("R2 registers unchanged");

    // R7 host NACK ends transmission
    busStart();
    writeByte(8'hD3, a);
    readByte(1'b1, d);
    check(d == 8'h07, "R6 count before nack", d, 8'h07);
    readByte(1'b0, d);
    check(d == expView(0), "R6 first register", d, expView(0));
    for (int i = 0; i < 9; i++) begin
      bit b;
      recvBit(b);
      check(b == 1'b1, "R7 sda released after nack", {7'd0, b}, 8'h01);
    end
    busStop();

    // R8 status inputs change; writes cannot touch them
    selStatus = 2'b01; swingStatus = 1'b0; deviceId = 8'h3C;
    for (int i = 0; i < 6; i++) wrBuf[i] = 8'h00;
    doWrite(8'hD2, 6, 8'h12, 8'h06);
    modelWrite(6);
    checkView("R8 status bits");
    fullReadCheck("R8 readback");

    // Random block writes with periodic block reads
    for (int it = 0; it < 24; it++) begin
      int n;
      n = $urandom_range(0, 8);
      for (int i = 0; i < n; i++) wrBuf[i] = 8'($urandom);
      doWrite(8'hD2, n, 8'($urandom), 8'($urandom));
      for (int i = 0; i < n + 3; i++)
        check(ackBuf[i], "R4 ack in random write", {7'd0, ackBuf[i]}, 8'h01);
      modelWrite(n);
      checkView("R4 R9 random write");
      if (it % 6 == 5) fullReadCheck("R6 random readback");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule